// File: doc/BRIEF.md
# Random Replacement Index Generator

This block picks the entry that a translation buffer overwrites when a new mapping has to be installed and software has not named a slot. The low entries of the buffer can be reserved: a boundary input gives the number of locked entries at the bottom, and the generated index always falls between that boundary and the highest entry. A pseudo-random source is kept in a 32-bit Galois shift register that advances once for every candidate it produces.

The raw random word is reduced into the allowed span by a sequential remainder unit, one quotient bit per clock. If a candidate equals the index handed out last time, the generator advances the shift register and reduces again. It repeats this until the candidate differs, so two successive results never match. When the boundary leaves one free entry or none, the reduction is skipped and the highest entry is returned straight away.

A request is a one-cycle strobe. The result comes back as an index that holds its value plus a one-cycle valid pulse. Strobes that arrive while a result is still being worked out are dropped.

Top module: `rnd_index_gen`

## Requirements
- R1: After reset the index output is 0, valid is low, the shift register holds 1 and the remembered previous index is 0.
- R2: Each advance shifts the 32-bit register right by one; when the bit shifted out was 1, the shifted value is XORed with 32'hD0000001. The register never holds zero.
- R3: With E entries and W locked entries, every candidate is formed by first advancing the register and then taking (register mod (E - W)) + W.
- R4: When W < E - 1, a returned index never equals the index returned just before it. A candidate that matches it causes another advance and another reduction.
- R5: When W >= E - 1, the index returned is E - 1. Valid rises one cycle after the request edge, and the shift register does not advance.
- R6: For W < E - 1, valid rises 33 cycles after the request edge for each candidate tried. Valid is a single-cycle pulse, and the index holds its value until the next result.
- R7: A request strobe, together with any change of E or W, that arrives while a result is pending is ignored. It changes neither the pending result nor the random sequence.
- R8: E may range from 1 to 64, W from 0 to E, and the index is 6 bits wide, so E = 64 yields indices up to 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle strobe asking for a new index |
| entries | input | 7 | Total entry count E, sampled with an accepted request |
| wired | input | 7 | Locked entry count W, sampled with an accepted request |
| idx | output | 6 | Most recent replacement index |
| valid | output | 1 | One-cycle pulse marking a fresh index |

## Verification
A result in the locked-out case is due one cycle after the request edge. Every other result is due 33 cycles after the edge for each candidate the bench model needed, so the bench counts edges from the strobe and compares that count with 1 or 1 + 33 times the attempt count. The index is sampled on the falling edge where valid is first seen high, and the next falling edge must show valid low again. A reference shift register and previous-index copy kept in the bench predict both the index and the attempt count. Because of this, dropped strobes injected mid-computation, and skipped advances in the locked-out case, show up as mismatches on later results.

// File: rtl/rnd_idx_pkg.sv
package rnd_idx_pkg;

    localparam int unsigned RND_W     = 32;
    localparam logic [RND_W-1:0] RND_TAPS = 32'hD000_0001;
    localparam logic [RND_W-1:0] RND_SEED = 32'h0000_0001;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } ctl_state_e;

    // advance the Galois register by one position
    function automatic logic [RND_W-1:0] rnd_advance(input logic [RND_W-1:0] cur);
        return (cur >> 1) ^ ({RND_W{cur[0]}} & RND_TAPS);
    endfunction

endpackage

// File: rtl/rnd_lfsr.sv
module rnd_lfsr
    import rnd_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [RND_W-1:0] cur,
    output logic [RND_W-1:0] nxt
);
    logic [RND_W-1:0] reg_q;

    assign cur = reg_q;
    assign nxt = rnd_advance(reg_q);

    always_ff @(posedge clk) begin
        if (rst)      reg_q <= RND_SEED;
        else if (adv) reg_q <= nxt;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        reg_q != '0); // R2

endmodule

// File: rtl/rnd_rem_div.sv
module rnd_rem_div #(
    parameter int unsigned DVD_W = 32,
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic [DIV_W-1:0] rem
);
    localparam int unsigned CNT_W = $clog2(DVD_W + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DVD_W);

    logic [DVD_W-1:0] dvd_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [DIV_W:0]   shifted;
    logic [DIV_W:0]   trial;

    assign shifted = {rem_q, dvd_q[DVD_W-1]};
    assign trial   = shifted - {1'b0, div_q};
    assign done    = busy_q && (cnt_q == '0);
    assign rem     = rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            div_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            dvd_q  <= dividend;
            div_q  <= divisor;
            rem_q  <= '0;
            cnt_q  <= CNT_INIT;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                dvd_q <= dvd_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (shifted >= {1'b0, div_q}) rem_q <= trial[DIV_W-1:0];
                else                          rem_q <= shifted[DIV_W-1:0];
            end
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        done |-> rem_q < div_q); // R3

endmodule

// File: rtl/rnd_index_gen.sv
module rnd_index_gen
    import rnd_idx_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [IDX_W:0]   entries,
    input  logic [IDX_W:0]   wired,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    localparam int unsigned CNT_W = IDX_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] fixed;
    } span_cfg_t;

    ctl_state_e       state_q;
    span_cfg_t        cfg_q;
    logic [IDX_W-1:0] idx_q;   // doubles as the previous-index memory
    logic             valid_q;

    logic             adv;
    logic             div_start;
    logic             div_done;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] divisor;
    logic [CNT_W-1:0] cand;
    logic [CNT_W-1:0] last_in;
    logic             degen_in;
    logic             degen_q;
    logic             repeat_hit;
    logic [RND_W-1:0] rnd_cur;
    logic [RND_W-1:0] rnd_nxt;

    assign last_in    = entries - 1'b1;
    assign degen_in   = wired >= last_in;
    assign degen_q    = cfg_q.fixed >= (cfg_q.total - 1'b1);
    assign cand       = rem + cfg_q.fixed;
    assign repeat_hit = cand == {1'b0, idx_q};
    assign divisor    = (state_q == ST_IDLE) ? (entries - wired)
                                             : (cfg_q.total - cfg_q.fixed);

    always_comb begin
        adv       = 1'b0;
        div_start = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req && !degen_in) begin
                adv       = 1'b1;
                div_start = 1'b1;
            end
            ST_DIV: if (div_done && repeat_hit) begin
                adv       = 1'b1;
                div_start = 1'b1;
            end
            default: ;
        endcase
    end

    rnd_lfsr u_lfsr (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .cur (rnd_cur),
        .nxt (rnd_nxt)
    );

    rnd_rem_div #(.DVD_W(RND_W), .DIV_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (rnd_nxt),
        .divisor  (divisor),
        .done     (div_done),
        .rem      (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req) begin
                    cfg_q <= '{total: entries, fixed: wired};
                    if (degen_in) begin
                        idx_q   <= last_in[IDX_W-1:0];
                        valid_q <= 1'b1;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: if (div_done && !repeat_hit) begin
                    idx_q   <= cand[IDX_W-1:0];
                    valid_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idx   = idx_q;
    assign valid = valid_q;

    AST_IDX_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !degen_q) |-> ({1'b0, idx_q} >= cfg_q.fixed && {1'b0, idx_q} < cfg_q.total)); // R3

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !degen_q) |-> idx_q != $past(idx_q)); // R4

    AST_DEGEN_HOLDS_RNG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req && degen_in) |=> $stable(rnd_cur)); // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R6

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV && req) |=> $stable(cfg_q)); // R7

endmodule

// File: tb/sim_rnd_index_gen.sv
module sim_rnd_index_gen;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic [IDX_W:0]   entries = '0;
    logic [IDX_W:0]   wired = '0;
    logic [IDX_W-1:0] idx;
    logic             valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_rng = 32'd1;
    int m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_index_gen #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .req(req), .entries(entries), .wired(wired),
        .idx(idx), .valid(valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] v);
        return (v >> 1) ^ ({32{v[0]}} & 32'hD000_0001);
    endfunction

    // poke > 0: inject a stray request with junk config at that cycle count
    task automatic run_req(input int e, input int w, input int poke);
        int exp_idx;
        int tries;
        int exp_lat;
        int lat;
        int cand;
        tries = 0;
        if (w >= e - 1) begin
            exp_idx = e - 1;
            exp_lat = 1;
        end else begin
            do begin
                m_rng = m_step(m_rng);
                cand  = int'(m_rng % 32'(e - w)) + w;
                tries++;
            end while (cand == m_prev);
            exp_idx = cand;
            exp_lat = 1 + 33 * tries;
        end
        m_prev = exp_idx;

        entries = 7'(e);
        wired   = 7'(w);
        req     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!valid && lat < 2000) begin
            if (lat == poke) begin
                req = 1'b1; entries = 7'd40; wired = 7'd3;
            end else begin
                req = 1'b0; entries = 7'(e); wired = 7'(w);
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        req = 1'b0;
        check(lat == exp_lat, poke > 0 ? "R7 latency with stray request" : "R6 latency", lat, exp_lat);
        check(int'(idx) == exp_idx,
              (w >= e - 1) ? "R5 locked-out index" : (e == 64 ? "R8 index at 64 entries" : "R3 R4 index"),
              int'(idx), exp_idx);
        @(posedge clk);
        @(negedge clk);
        check(!valid, "R6 valid pulse width", int'(valid), 0);
        check(int'(idx) == exp_idx, "R6 index held", int'(idx), exp_idx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(idx == '0, "R1 reset index", int'(idx), 0);
        check(!valid, "R1 reset valid", int'(valid), 0);

        // first result checks seed 1 and the R2 step rule
        run_req(8, 0, 0);

        for (int e = 1; e <= 12; e++)
            for (int w = 0; w <= e; w++)
                for (int k = 0; k < 2; k++)
                    run_req(e, w, 0);

        // R8: full 64-entry span and boundaries
        for (int k = 0; k < 4; k++) run_req(64, 0, 0);
        for (int k = 0; k < 3; k++) run_req(64, 1, 0);
        for (int k = 0; k < 3; k++) run_req(64, 32, 0);
        run_req(64, 62, 0);
        run_req(64, 62, 0);
        run_req(64, 63, 0);
        run_req(64, 64, 0);

        // R7: stray requests during computation
        run_req(16, 2, 5);
        run_req(16, 2, 20);
        run_req(5, 1, 33);
        run_req(3, 1, 2);
        run_req(16, 2, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule